// File: doc/BRIEF.md
# SDRAM Command Sequencer with Periodic Refresh

This block turns single-word read and write requests into SDRAM command-bus traffic. A requester offers a flat address and a direction on a valid/ready port. The sequencer splits the address into rank, bank, row and column fields. It opens the row, issues the column command and moves one data burst. It then closes the row with a precharge to all banks of that rank. Every access therefore leaves every bank closed, and a refresh never has to wait for open rows to be closed.

Command outputs come straight from flops. Chip selects are active-low and there is one select per rank. A shared address bus carries the row during activate and the column during read or write. A free-running interval timer raises a refresh request, and that request is served ahead of any waiting access.

Parameters give the activate-to-column delay, the CAS latency, the write latency, the precharge time, the refresh cycle time and the refresh interval, all counted in clock cycles. One parameter accounts for modules that register address and command. Another selects the older four-bank device generation with four-beat bursts. Read data is captured from the memory data input one beat per clock. Write data is pulled from the requester one beat per clock.

Top module: `sdram_cmd_seq`

## Requirements
- R1: The flat request address is split, from bit 0 upward, into a 10-bit column [9:0], a 3-bit bank [12:10], a 15-bit row [27:13] and a 3-bit rank [30:28]. Activate, column and precharge commands drive low only the chip select whose index equals the rank.
- R2: The command is encoded on {ras_n, cas_n, we_n} as follows: activate 011, read 101, write 100, precharge 010, refresh 001. Every other cycle carries NOP 111 with all chip selects low.
- R3: The activate appears on the bus in the cycle after a request is accepted, and it drives the row on the address bus and the bank on the bank lines. The read or write command appears exactly TRCD cycles after the activate. It carries the column on address bits [9:0], with bits [14:10] at zero.
- R4: For a read, beat i is taken from mem_dq_in in cycle RL+i after the read command. It appears on rd_data with rd_valid in the following cycle. rd_last marks the final beat. RL is CL, or CL+1 when REGISTERED is set.
- R5: For a write, wr_take is high in cycles WL-1+i after the write command, and wr_data is consumed at the end of each of those cycles. That beat is driven on mem_dq_out with mem_dq_oe high in cycle WL+i. WL is WR_LAT, or WR_LAT+1 when REGISTERED is set.
- R6: A burst has 8 beats, or 4 beats when DDR2_MODE is set.
- R7: In the cycle after the last beat (the cycle of the last rd_valid for a read, or the cycle after the last mem_dq_oe beat for a write), a precharge is issued to the accessed rank and bank with address bit 10 set.
- R8: req_ready falls in the cycle after an acceptance. It stays low until TRP cycles after the precharge.
- R9: A refresh request is raised every REF_INT cycles after reset. While it is pending, req_ready is low. When the sequencer is idle it issues a refresh with all chip selects low, ahead of any waiting request. It stays busy for TRFC cycles after the refresh.
- R10: When DDR2_MODE is set, the top bank line is always 0 and address bit 12 has no effect.
- R11: During and right after reset the bus carries NOP, rd_valid, rd_last and mem_dq_oe are low, and the refresh interval restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 31 | Flat word address |
| wr_data | input | 64 | Write beat, consumed when wr_take is high |
| wr_take | output | 1 | Current write beat is consumed at this edge |
| rd_data | output | 64 | Read beat |
| rd_valid | output | 1 | rd_data holds a beat |
| rd_last | output | 1 | Final read beat of the burst |
| mem_cs_n | output | 8 | Per-rank chip selects, active low |
| mem_ras_n | output | 1 | Row strobe command wire |
| mem_cas_n | output | 1 | Column strobe command wire |
| mem_we_n | output | 1 | Write enable command wire |
| mem_ba | output | 3 | Bank lines |
| mem_a | output | 15 | Multiplexed row/column address |
| mem_dq_out | output | 64 | Write data to memory |
| mem_dq_oe | output | 1 | mem_dq_out is driven |
| mem_dq_in | input | 64 | Read data from memory |

## Verification
Every result has a fixed cycle offset. The activate comes one cycle after acceptance, and the column command comes TRCD cycles after that. A read beat is captured from the data input at RL+i and shown one cycle later. A write beat is requested at WL-1+i and driven at WL+i. The precharge follows the last beat, and ready returns TRP cycles after the precharge. The bench advances a behavioural reference at each rising edge, with integer counters and a request queue, and compares every output with the reference at the falling edge. Because the data input changes every cycle, a latency that is off by one cycle shows up as wrong data. Two configurations run side by side: the default one, and one with registered modules and four-beat, four-bank operation.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_RCD  = 3'd1,
        ST_XFER = 3'd2,
        ST_RP   = 3'd3,
        ST_REFW = 3'd4
    } seq_state_e;

    // {ras_n, cas_n, we_n}
    typedef enum logic [2:0] {
        CMD_ACT = 3'b011,
        CMD_RD  = 3'b101,
        CMD_WR  = 3'b100,
        CMD_PRE = 3'b010,
        CMD_REF = 3'b001,
        CMD_NOP = 3'b111
    } mem_cmd_e;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdram_addr_split.sv
module sdram_addr_split #(
    parameter int COL_W     = 10,
    parameter int BANK_W    = 3,
    parameter int ROW_W     = 15,
    parameter int RANK_W    = 3,
    parameter bit DDR2_MODE = 1'b0,
    localparam int AW       = COL_W + BANK_W + ROW_W + RANK_W
) (
    input  logic [AW-1:0]     flat_addr,
    output logic [COL_W-1:0]  col,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [RANK_W-1:0] rank
);
    localparam int BANK_LO = COL_W;
    localparam int ROW_LO  = COL_W + BANK_W;
    localparam int RANK_LO = ROW_LO + ROW_W;

    logic [BANK_W-1:0] bank_raw;

    assign col      = flat_addr[COL_W-1:0];
    assign bank_raw = flat_addr[BANK_LO +: BANK_W];
    assign row      = flat_addr[ROW_LO +: ROW_W];
    assign rank     = flat_addr[RANK_LO +: RANK_W];

    generate
        if (DDR2_MODE) begin : g_four_bank
            assign bank = {1'b0, bank_raw[BANK_W-2:0]};
        end else begin : g_all_bank
            assign bank = bank_raw;
        end
    endgenerate

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
    parameter int unsigned REF_INT = 200,
    localparam int TW = $clog2(REF_INT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    output logic pend
);
    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          pend;
    } tmr_t;

    tmr_t q, d;
    logic expire;

    always_comb begin
        d      = q;
        expire = (q.cnt == TW'(REF_INT - 1));
        d.cnt  = expire ? '0 : q.cnt + 1'b1;
        d.pend = (q.pend && !grant) || expire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pend = q.pend;

endmodule

// File: rtl/sdram_burst_window.sv
module sdram_burst_window #(
    parameter int unsigned RL = 5,
    parameter int unsigned WL = 4,
    parameter int unsigned BL = 8,
    parameter int TW          = 5
) (
    input  logic          active,
    input  logic          is_write,
    input  logic [TW-1:0] t,
    output logic          take,
    output logic          capture,
    output logic          last,
    output logic          done
);
    localparam int unsigned RD_END = RL + BL - 1;
    localparam int unsigned WR_END = WL + BL - 1;

    always_comb begin
        take    = active && is_write
                  && (t >= TW'(WL - 1)) && (t < TW'(WL - 1 + BL));
        capture = active && !is_write
                  && (t >= TW'(RL)) && (t <= TW'(RD_END));
        last    = capture && (t == TW'(RD_END));
        done    = active && (t == (is_write ? TW'(WR_END) : TW'(RD_END)));
    end

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int unsigned TRCD       = 3,
    parameter int unsigned CL         = 5,
    parameter int unsigned WR_LAT     = 4,
    parameter int unsigned TRP        = 3,
    parameter int unsigned TRFC       = 8,
    parameter int unsigned REF_INT    = 200,
    parameter bit          REGISTERED = 1'b0,
    parameter bit          DDR2_MODE  = 1'b0,
    parameter int          COL_W      = 10,
    parameter int          BANK_W     = 3,
    parameter int          ROW_W      = 15,
    parameter int          RANK_W     = 3,
    parameter int          DW         = 64,
    localparam int         NRANK      = 1 << RANK_W,
    localparam int         AW         = COL_W + BANK_W + ROW_W + RANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     wr_data,
    output logic              wr_take,
    output logic [DW-1:0]     rd_data,
    output logic              rd_valid,
    output logic              rd_last,
    output logic [NRANK-1:0]  mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [BANK_W-1:0] mem_ba,
    output logic [ROW_W-1:0]  mem_a,
    output logic [DW-1:0]     mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DW-1:0]     mem_dq_in
);
    localparam int unsigned BL     = DDR2_MODE ? 4 : 8;
    localparam int unsigned RL     = CL + (REGISTERED ? 1 : 0);
    localparam int unsigned WL     = WR_LAT + (REGISTERED ? 1 : 0);
    localparam int unsigned XMAX   = max2(RL, WL) + BL + 1;
    localparam int          TW     = $clog2(XMAX + 1);
    localparam int unsigned CMAX   = max2(max2(TRCD, TRP), TRFC);
    localparam int          CW     = $clog2(CMAX + 1);
    localparam int          AP_BIT = 10;

    typedef struct packed {
        seq_state_e        st;
        logic [CW-1:0]     cnt;
        logic [TW-1:0]     t;
        logic              wr;
        logic [RANK_W-1:0] rank;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        mem_cmd_e          cmd;
        logic [NRANK-1:0]  cs_n;
        logic [BANK_W-1:0] ba;
        logic [ROW_W-1:0]  a;
        logic              rv;
        logic              last;
        logic [DW-1:0]     rdata;
        logic              oe;
        logic [DW-1:0]     dout;
    } seq_t;

    seq_t q, d;

    logic [COL_W-1:0]  a_col;
    logic [BANK_W-1:0] a_bank;
    logic [ROW_W-1:0]  a_row;
    logic [RANK_W-1:0] a_rank;
    logic              ref_pend, ref_grant;
    logic              w_take, w_cap, w_last, w_done;

    sdram_addr_split #(
        .COL_W(COL_W), .BANK_W(BANK_W), .ROW_W(ROW_W), .RANK_W(RANK_W),
        .DDR2_MODE(DDR2_MODE)
    ) u_split (
        .flat_addr(req_addr), .col(a_col), .bank(a_bank), .row(a_row), .rank(a_rank)
    );

    sdram_refresh_timer #(.REF_INT(REF_INT)) u_ref (
        .clk(clk), .rst_n(rst_n), .grant(ref_grant), .pend(ref_pend)
    );

    sdram_burst_window #(.RL(RL), .WL(WL), .BL(BL), .TW(TW)) u_win (
        .active(q.st == ST_XFER), .is_write(q.wr), .t(q.t),
        .take(w_take), .capture(w_cap), .last(w_last), .done(w_done)
    );

    always_comb begin
        d         = q;
        ref_grant = 1'b0;
        d.cmd     = CMD_NOP;
        d.cs_n    = '0;
        d.ba      = '0;
        d.a       = '0;
        d.rv      = 1'b0;
        d.last    = 1'b0;
        d.oe      = 1'b0;

        if (w_cap) begin
            d.rv    = 1'b1;
            d.rdata = mem_dq_in;
            d.last  = w_last;
        end
        if (w_take) begin
            d.oe   = 1'b1;
            d.dout = wr_data;
        end

        unique case (q.st)
            ST_IDLE: begin
                if (ref_pend) begin
                    ref_grant = 1'b1;
                    d.cmd     = CMD_REF;
                    d.st      = ST_REFW;
                    d.cnt     = CW'(TRFC - 1);
                end else if (req_valid) begin
                    d.wr   = req_write;
                    d.rank = a_rank;
                    d.bank = a_bank;
                    d.col  = a_col;
                    d.cmd  = CMD_ACT;
                    d.cs_n = ~(NRANK'(1) << a_rank);
                    d.ba   = a_bank;
                    d.a    = a_row;
                    d.st   = ST_RCD;
                    d.cnt  = CW'(TRCD - 1);
                end
            end
            ST_RCD: begin
                if (q.cnt == '0) begin
                    d.cmd  = q.wr ? CMD_WR : CMD_RD;
                    d.cs_n = ~(NRANK'(1) << q.rank);
                    d.ba   = q.bank;
                    d.a    = ROW_W'(q.col);
                    d.st   = ST_XFER;
                    d.t    = '0;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_XFER: begin
                if (w_done) begin
                    d.cmd       = CMD_PRE;
                    d.cs_n      = ~(NRANK'(1) << q.rank);
                    d.ba        = q.bank;
                    d.a         = '0;
                    d.a[AP_BIT] = 1'b1;
                    d.st        = ST_RP;
                    d.cnt       = CW'(TRP - 1);
                end else begin
                    d.t = q.t + 1'b1;
                end
            end
            ST_RP, ST_REFW: begin
                if (q.cnt == '0) d.st = ST_IDLE;
                else             d.cnt = q.cnt - 1'b1;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.cmd <= CMD_NOP;
        end else begin
            q <= d;
        end
    end

    assign req_ready  = (q.st == ST_IDLE) && !ref_pend;
    assign wr_take    = w_take;
    assign rd_data    = q.rdata;
    assign rd_valid   = q.rv;
    assign rd_last    = q.last;
    assign mem_cs_n   = q.cs_n;
    assign {mem_ras_n, mem_cas_n, mem_we_n} = q.cmd;
    assign mem_ba     = q.ba;
    assign mem_a      = q.a;
    assign mem_dq_out = q.dout;
    assign mem_dq_oe  = q.oe;

endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk #(
    parameter int unsigned TRCD      = 3,
    parameter bit          DDR2_MODE = 1'b0,
    parameter int          NRANK     = 8,
    parameter int          BANK_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [NRANK-1:0]  mem_cs_n,
    input logic              mem_ras_n,
    input logic              mem_cas_n,
    input logic              mem_we_n,
    input logic [BANK_W-1:0] mem_ba,
    input logic              rd_valid,
    input logic              mem_dq_oe
);
    logic [2:0] cmd;
    logic       is_act, is_col, is_pre, is_ref;
    int unsigned since_act;

    assign cmd    = {mem_ras_n, mem_cas_n, mem_we_n};
    assign is_act = (cmd == 3'b011);
    assign is_col = (cmd == 3'b101) || (cmd == 3'b100);
    assign is_pre = (cmd == 3'b010);
    assign is_ref = (cmd == 3'b001);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   since_act <= 0;
        else if (is_act)              since_act <= 1;
        else if (since_act < 1000000) since_act <= since_act + 1;
    end

    AST_ONE_RANK: assert property (@(posedge clk) disable iff (!rst_n)
        (is_act || is_col || is_pre) |-> ($countones(~mem_cs_n) == 1)); // R1
    AST_COL_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (since_act == TRCD)); // R3
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8
    AST_REF_ALL_RANKS: assert property (@(posedge clk) disable iff (!rst_n)
        is_ref |-> (mem_cs_n == '0)); // R9
    AST_DQ_ONE_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_valid && mem_dq_oe)); // R5
    AST_FOUR_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        DDR2_MODE |-> !mem_ba[BANK_W-1]); // R10

endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(
    .TRCD(TRCD), .DDR2_MODE(DDR2_MODE), .NRANK(NRANK), .BANK_W(BANK_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
    .mem_we_n(mem_we_n), .mem_ba(mem_ba), .rd_valid(rd_valid), .mem_dq_oe(mem_dq_oe)
);

// File: tb/tb_sdram_cmd_seq.sv
module seq_agent #(
    parameter int TRCD = 3, parameter int CL = 5, parameter int WR_LAT = 4,
    parameter int TRP = 3, parameter int TRFC = 8, parameter int REF_INT = 200,
    parameter bit REGISTERED = 1'b0, parameter bit DDR2_MODE = 1'b0,
    parameter int NREQ = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        req_valid,
    input  logic        req_ready,
    output logic        req_write,
    output logic [30:0] req_addr,
    output logic [63:0] wr_data,
    input  logic        wr_take,
    input  logic [63:0] rd_data,
    input  logic        rd_valid,
    input  logic        rd_last,
    input  logic [7:0]  mem_cs_n,
    input  logic        mem_ras_n,
    input  logic        mem_cas_n,
    input  logic        mem_we_n,
    input  logic [2:0]  mem_ba,
    input  logic [14:0] mem_a,
    input  logic [63:0] mem_dq_out,
    input  logic        mem_dq_oe,
    output logic [63:0] mem_dq_in
);
    localparam int BL = DDR2_MODE ? 4 : 8;
    localparam int RL = CL + (REGISTERED ? 1 : 0);
    localparam int WL = WR_LAT + (REGISTERED ? 1 : 0);

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    int unsigned cyc  = 0;
    int unsigned widx = 0;
    int acc_cnt = 0;

    // reference state
    int ph = 0, cnt = 0, t = 0, rtmr = 0;
    bit rpend = 0, cur_wr = 0;
    int c_rank = 0, c_bank = 0, c_row = 0, c_col = 0;
    logic [2:0]  e_cmd = 3'b111;
    logic [7:0]  e_cs = 8'h00;
    logic [2:0]  e_ba = 0;
    logic [14:0] e_a = 0;
    bit e_rv = 0, e_last = 0, e_oe = 0;
    logic [63:0] e_rd = 0, e_do = 0;

    assign mem_dq_in = {32'hD0D0_0000 | cyc[15:0], ~cyc};
    assign wr_data   = {32'hC0DE_0000 | widx[15:0], 32'h1234_0000 ^ widx};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %m cyc=%0d actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    function automatic bit in_take();
        return ph == 2 && cur_wr && t >= WL - 1 && t < WL - 1 + BL;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph = 0; cnt = 0; t = 0; rtmr = 0; rpend = 0;
            e_cmd = 3'b111; e_cs = 0; e_ba = 0; e_a = 0;
            e_rv = 0; e_last = 0; e_oe = 0;
            cyc  <= 0;
            widx <= 0;
        end else begin
            bit rdy, acc, expire, grant, tk;
            int endt;
            cyc <= cyc + 1;
            rdy = (ph == 0) && !rpend;
            acc = req_valid && rdy;
            tk  = in_take();
            e_cmd = 3'b111; e_cs = 0; e_ba = 0; e_a = 0;
            e_rv = 0; e_last = 0; e_oe = 0;
            if (ph == 2 && !cur_wr && t >= RL && t < RL + BL) begin
                e_rv = 1; e_rd = mem_dq_in; e_last = (t == RL + BL - 1);
            end
            if (tk) begin
                e_oe = 1; e_do = wr_data; widx <= widx + 1;
            end
            grant  = (ph == 0) && rpend;
            expire = (rtmr == REF_INT - 1);
            rtmr   = expire ? 0 : rtmr + 1;
            endt   = cur_wr ? WL + BL - 1 : RL + BL - 1;
            case (ph)
                0: if (rpend) begin
                       e_cmd = 3'b001; ph = 4; cnt = TRFC - 1;
                   end else if (acc) begin
                       acc_cnt++;
                       cur_wr = req_write;
                       c_col  = req_addr[9:0];
                       c_bank = DDR2_MODE ? req_addr[11:10] : req_addr[12:10];
                       c_row  = req_addr[27:13];
                       c_rank = req_addr[30:28];
                       e_cmd = 3'b011; e_cs = ~(8'd1 << c_rank);
                       e_ba = 3'(c_bank); e_a = 15'(c_row);
                       ph = 1; cnt = TRCD - 1;
                   end
                1: if (cnt == 0) begin
                       e_cmd = cur_wr ? 3'b100 : 3'b101; e_cs = ~(8'd1 << c_rank);
                       e_ba = 3'(c_bank); e_a = 15'(c_col);
                       ph = 2; t = 0;
                   end else cnt--;
                2: if (t == endt) begin
                       e_cmd = 3'b010; e_cs = ~(8'd1 << c_rank);
                       e_ba = 3'(c_bank); e_a = 15'h0400;
                       ph = 3; cnt = TRP - 1;
                   end else t++;
                default: if (cnt == 0) ph = 0; else cnt--;
            endcase
            rpend = (rpend && !grant) || expire;
        end
    end

    // compare on every clock, away from the rising edge
    always @(negedge clk) begin
        bit cmd_is_ref, cmd_is_busy;
        cmd_is_ref  = (e_cmd == 3'b001);
        cmd_is_busy = (e_cmd != 3'b111);
        if (!rst_n) begin
            chk("R11 reset cmd", {mem_ras_n, mem_cas_n, mem_we_n}, 3'b111);
            chk("R11 reset rd_valid", rd_valid, 0);
            chk("R11 reset dq_oe", mem_dq_oe, 0);
        end else begin
            chk(cmd_is_ref ? "R9 refresh cmd" : "R2 cmd", {mem_ras_n, mem_cas_n, mem_we_n}, e_cmd);
            chk(cmd_is_ref ? "R9 refresh cs_n" : "R1 cs_n", mem_cs_n, e_cs);
            chk(DDR2_MODE ? "R10 bank" : "R1 bank", mem_ba, e_ba);
            chk(cmd_is_busy ? "R3 addr" : "R2 nop addr", mem_a, e_a);
            chk("R8 R9 req_ready", req_ready, (ph == 0) && !rpend);
            chk("R4 rd_valid", rd_valid, e_rv);
            chk("R6 rd_last", rd_last, e_last);
            if (e_rv) chk("R4 rd_data", rd_data, e_rd);
            chk("R5 dq_oe", mem_dq_oe, e_oe);
            if (e_oe) chk("R5 dq_out", mem_dq_out, e_do);
            chk("R5 wr_take", wr_take, in_take());
            if (e_cmd == 3'b010) chk("R7 precharge a10", mem_a[10], 1);
        end
    end

    // stimulus
    initial begin
        req_valid = 0; req_write = 0; req_addr = 0;
        @(posedge rst_n);
        repeat (3) @(negedge clk);
        for (int i = 0; i < NREQ; i++) begin
            logic [2:0] rk, bk;
            logic [14:0] rw;
            logic [9:0] cl;
            rk = 3'(i % 8);
            bk = 3'((i * 5 + 1) % 8);
            rw = 15'((i * 1237 + 77) % 32768);
            cl = 10'((i * 37 + 3) % 1024);
            repeat (i % 3) @(negedge clk);
            req_valid = 1;
            req_write = (i % 3) != 1;
            req_addr  = {rk, rw, bk, cl};
            while (acc_cnt <= i) @(negedge clk);
            req_valid = 0;
        end
        while (ph != 0) @(negedge clk);
        repeat (2 * REF_INT) @(negedge clk);
        done = 1;
    end

endmodule

module tb_sdram_cmd_seq;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic clk = 0;
    logic rst_n = 0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    // default configuration
    logic        a_vld, a_rdy, a_wr, a_take, a_rv, a_last, a_ras, a_cas, a_we, a_oe;
    logic [30:0] a_addr;
    logic [63:0] a_wd, a_rd, a_do, a_di;
    logic [7:0]  a_cs;
    logic [2:0]  a_ba;
    logic [14:0] a_a;

    // registered modules, four banks, four-beat bursts
    logic        b_vld, b_rdy, b_wr, b_take, b_rv, b_last, b_ras, b_cas, b_we, b_oe;
    logic [30:0] b_addr;
    logic [63:0] b_wd, b_rd, b_do, b_di;
    logic [7:0]  b_cs;
    logic [2:0]  b_ba;
    logic [14:0] b_a;

    sdram_cmd_seq #(.REF_INT(50)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(a_vld), .req_ready(a_rdy),
        .req_write(a_wr), .req_addr(a_addr), .wr_data(a_wd), .wr_take(a_take),
        .rd_data(a_rd), .rd_valid(a_rv), .rd_last(a_last), .mem_cs_n(a_cs),
        .mem_ras_n(a_ras), .mem_cas_n(a_cas), .mem_we_n(a_we), .mem_ba(a_ba),
        .mem_a(a_a), .mem_dq_out(a_do), .mem_dq_oe(a_oe), .mem_dq_in(a_di)
    );

    seq_agent #(.REF_INT(50)) u_ag_a (
        .clk(clk), .rst_n(rst_n), .req_valid(a_vld), .req_ready(a_rdy),
        .req_write(a_wr), .req_addr(a_addr), .wr_data(a_wd), .wr_take(a_take),
        .rd_data(a_rd), .rd_valid(a_rv), .rd_last(a_last), .mem_cs_n(a_cs),
        .mem_ras_n(a_ras), .mem_cas_n(a_cas), .mem_we_n(a_we), .mem_ba(a_ba),
        .mem_a(a_a), .mem_dq_out(a_do), .mem_dq_oe(a_oe), .mem_dq_in(a_di)
    );

    sdram_cmd_seq #(.TRCD(2), .CL(4), .WR_LAT(3), .TRP(2), .TRFC(6), .REF_INT(70),
                    .REGISTERED(1'b1), .DDR2_MODE(1'b1)) dut_r (
        .clk(clk), .rst_n(rst_n), .req_valid(b_vld), .req_ready(b_rdy),
        .req_write(b_wr), .req_addr(b_addr), .wr_data(b_wd), .wr_take(b_take),
        .rd_data(b_rd), .rd_valid(b_rv), .rd_last(b_last), .mem_cs_n(b_cs),
        .mem_ras_n(b_ras), .mem_cas_n(b_cas), .mem_we_n(b_we), .mem_ba(b_ba),
        .mem_a(b_a), .mem_dq_out(b_do), .mem_dq_oe(b_oe), .mem_dq_in(b_di)
    );

    seq_agent #(.TRCD(2), .CL(4), .WR_LAT(3), .TRP(2), .TRFC(6), .REF_INT(70),
                .REGISTERED(1'b1), .DDR2_MODE(1'b1)) u_ag_b (
        .clk(clk), .rst_n(rst_n), .req_valid(b_vld), .req_ready(b_rdy),
        .req_write(b_wr), .req_addr(b_addr), .wr_data(b_wd), .wr_take(b_take),
        .rd_data(b_rd), .rd_valid(b_rv), .rd_last(b_last), .mem_cs_n(b_cs),
        .mem_ras_n(b_ras), .mem_cas_n(b_cas), .mem_we_n(b_we), .mem_ba(b_ba),
        .mem_a(b_a), .mem_dq_out(b_do), .mem_dq_oe(b_oe), .mem_dq_in(b_di)
    );

    initial begin
        int total, fails;
        bit hung;
        hung = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        for (int c = 0; c < WATCHDOG; c++) begin
            @(negedge clk);
            if (u_ag_a.done && u_ag_b.done) break;
            if (c == WATCHDOG - 1) hung = 1;
        end
        total = u_ag_a.n_checks + u_ag_b.n_checks;
        fails = u_ag_a.n_fails + u_ag_b.n_fails;
        if (hung) begin
            total++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        end
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule